// File: doc/BRIEF.md
# I2C Target Byte Controller

This block is the byte-level sequencer for the target side of an I2C link. A bit-level front end feeds it one-cycle strobes for SCL rising and falling edges, the sampled SDA level, and one-cycle START and STOP detect pulses. The block shifts in the address byte and compares its upper seven bits with a programmed address. On a match it acknowledges. It then either receives write bytes, handing each to the host, or sends read bytes that the host supplies on request. An acknowledge slot follows every byte.

The only output toward the bus is an SDA pull-low enable. It changes only in the cycle after an SCL falling-edge strobe, and is forced to release when a START or STOP arrives. A START or STOP seen during a transaction takes the sequencer out of its current state through an ordinary transition, so the pull-low enable falls once and does not pulse. If the state register ever holds an encoding outside the legal set, the sequencer enters a halt state. It stays there until reset and reports it on an error output.

Top module: `i2c_tgt_byte_ctrl`

## Requirements
- R1: After reset, `sda_pull` is 0, and `rx_valid`, `tx_req` and `fsm_err` are all 0.
- R2: After a START, address bits are taken MSB first on `scl_rise` strobes. Bit 0 of the byte is the direction: 1 means read, 0 means write. The target acknowledges only when byte bits [7:1] equal `own_addr`. It acknowledges by driving `sda_pull` = 1 from the falling edge after the eighth bit to the next falling edge. On a mismatch it never drives and ignores all bits until the next START.
- R3: In a write, each byte completes on its eighth rising edge. It appears on `rx_byte` with a one-cycle `rx_valid` pulse and is acknowledged. The target then stays ready for a further byte.
- R4: In a read, `tx_req` pulses for one cycle after a read address match and after each controller ACK. `tx_data` is captured on the next `scl_fall`. Its bits go out MSB first with `sda_pull` = NOT bit, updated on each falling edge.
- R5: In a read, a controller NACK (`sda_in` = 1 at the rising edge of the ninth clock) returns the target to idle with SDA released. No further `tx_req` is issued.
- R6: A START during a transaction releases SDA and restarts address reception. Bits already taken are discarded.
- R7: A STOP during a transaction, including in the middle of a byte, releases SDA and returns to idle. The bits that follow are ignored until a START.
- R8: `sda_pull` rises only in the cycle after an `scl_fall` strobe. It is 0 in every state other than the acknowledge slot and the read data bits.
- R9: An illegal state encoding leads to a halt state on the next clock. There `fsm_err` = 1 and `sda_pull` = 0, and START, STOP and SCL strobes have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| sda_in | input | 1 | Synchronized SDA level |
| start_det | input | 1 | One-cycle START (or repeated START) detect |
| stop_det | input | 1 | One-cycle STOP detect |
| own_addr | input | 7 | Programmed 7-bit target address |
| tx_data | input | 8 | Next read byte supplied by the host |
| sda_pull | output | 1 | 1 = pull SDA low |
| rx_byte | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle pulse: rx_byte is new |
| tx_req | output | 1 | One-cycle request for the next read byte |
| fsm_err | output | 1 | Sequencer is halted after an illegal state |

## Verification
The assertions take for granted that the front end never raises two strobes in the same cycle. They also assume at least two idle cycles between strobes, so a single-cycle step such as the read-data request always finishes before the next SCL edge. The bench drives every strobe as a one-cycle pulse followed by two quiet cycles, and changes `sda_in` only between a falling and a rising strobe. The host model answers `tx_req` on the following cycle, well before the falling edge that captures the data.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    TS_IDLE       = 4'h0,
    TS_ADDR_RX    = 4'h1,
    TS_ACK_SLOT   = 4'h2,
    TS_WR_RX      = 4'h3,
    TS_RD_PRELOAD = 4'h4,
    TS_RD_TX      = 4'h5,
    TS_RD_ACKCHK  = 4'h6,
    TS_HALT       = 4'h7
  } tgt_state_t;

  // A transaction is in progress in these states only.
  function automatic logic is_target_state(input tgt_state_t s);
    case (s)
      TS_ADDR_RX, TS_ACK_SLOT, TS_WR_RX,
      TS_RD_PRELOAD, TS_RD_TX, TS_RD_ACKCHK: return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

  function automatic logic is_legal_state(input tgt_state_t s);
    return is_target_state(s) || (s == TS_IDLE) || (s == TS_HALT);
  endfunction

endpackage

// File: rtl/i2c_tgt_addr_cmp.sv
module i2c_tgt_addr_cmp #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic [DATA_W-1:0] full_byte,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              addr_hit,
  output logic              rw_bit
);

  function automatic logic match_addr(input logic [DATA_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
    return b[DATA_W-1:1] == a;
  endfunction

  assign addr_hit = match_addr(full_byte, own_addr);
  assign rw_bit   = full_byte[0];

endmodule

// File: rtl/i2c_tgt_shreg.sv
module i2c_tgt_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_in_en,
  input  logic              in_bit,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_out_en,
  output logic              sh_msb,
  output logic [DATA_W-1:0] full_byte
);

  logic [DATA_W-1:0] sh_q;

  // Byte as it stands once the current input bit is appended.
  assign full_byte = {sh_q[DATA_W-2:0], in_bit};
  assign sh_msb    = sh_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load_en) begin
      // MSB goes straight to the bus; keep the remaining bits.
      sh_q <= {load_val[DATA_W-2:0], 1'b0};
    end else if (shift_in_en) begin
      sh_q <= full_byte;
    end else if (shift_out_en) begin
      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_in,
  input  logic start_det,
  input  logic stop_det,
  input  logic addr_hit,
  input  logic rw_bit,
  input  logic tx_msb,
  input  logic sh_msb,
  output logic sda_pull,
  output logic tx_req,
  output logic byte_done,
  output logic sh_in_en,
  output logic sh_ld_en,
  output logic sh_out_en,
  output logic halted
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

  tgt_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pull_q, pull_d;
  logic             ack_on_q, ack_on_d;
  logic             rw_q, rw_d;
  logic             req_q, req_d;

  // Named internal events for the assertions.
  logic tgt_active;
  logic bus_evt;
  logic illegal_now;
  assign tgt_active  = is_target_state(st_q);
  assign bus_evt     = (start_det || stop_det) && tgt_active;
  assign illegal_now = !is_legal_state(st_q);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    pull_d    = pull_q;
    ack_on_d  = ack_on_q;
    rw_d      = rw_q;
    req_d     = 1'b0;
    sh_in_en  = 1'b0;
    sh_ld_en  = 1'b0;
    sh_out_en = 1'b0;
    byte_done = 1'b0;
    if (bus_evt) begin
      // Orderly exit: ordinary transition, SDA released once.
      pull_d   = 1'b0;
      cnt_d    = '0;
      ack_on_d = 1'b0;
      st_d     = start_det ? TS_ADDR_RX : TS_IDLE;
    end else begin
      case (st_q)
        TS_IDLE: begin
          if (start_det) begin
            st_d  = TS_ADDR_RX;
            cnt_d = '0;
          end
        end
        TS_ADDR_RX: begin
          if (scl_rise) begin
            sh_in_en = 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d = '0;
              if (addr_hit) begin
                rw_d  = rw_bit;
                req_d = rw_bit;
                st_d  = TS_ACK_SLOT;
              end else begin
                st_d = TS_IDLE;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        TS_ACK_SLOT: begin
          if (scl_fall) begin
            if (!ack_on_q) begin
              ack_on_d = 1'b1;
              pull_d   = 1'b1;
            end else begin
              ack_on_d = 1'b0;
              if (rw_q) begin
                sh_ld_en = 1'b1;
                pull_d   = ~tx_msb;
                cnt_d    = CNT_W'(1);
                st_d     = TS_RD_TX;
              end else begin
                pull_d = 1'b0;
                cnt_d  = '0;
                st_d   = TS_WR_RX;
              end
            end
          end
        end
        TS_WR_RX: begin
          if (scl_rise) begin
            sh_in_en = 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d     = '0;
              byte_done = 1'b1;
              st_d      = TS_ACK_SLOT;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        TS_RD_PRELOAD: begin
          if (scl_fall) begin
            sh_ld_en = 1'b1;
            pull_d   = ~tx_msb;
            cnt_d    = CNT_W'(1);
            st_d     = TS_RD_TX;
          end
        end
        TS_RD_TX: begin
          if (scl_fall) begin
            if (cnt_q == ALL_BITS) begin
              pull_d = 1'b0;
              cnt_d  = '0;
              st_d   = TS_RD_ACKCHK;
            end else begin
              sh_out_en = 1'b1;
              pull_d    = ~sh_msb;
              cnt_d     = cnt_q + 1'b1;
            end
          end
        end
        TS_RD_ACKCHK: begin
          if (scl_rise) begin
            if (sda_in) begin
              st_d = TS_IDLE;
            end else begin
              req_d = 1'b1;
              st_d  = TS_RD_PRELOAD;
            end
          end
        end
        TS_HALT: begin
          pull_d = 1'b0;
        end
        default: begin
          st_d   = TS_HALT;
          pull_d = 1'b0;
          cnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= TS_IDLE;
      cnt_q    <= '0;
      pull_q   <= 1'b0;
      ack_on_q <= 1'b0;
      rw_q     <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      pull_q   <= pull_d;
      ack_on_q <= ack_on_d;
      rw_q     <= rw_d;
      req_q    <= req_d;
    end
  end

  assign sda_pull = pull_q;
  assign tx_req   = req_q;
  assign halted   = (st_q == TS_HALT);

  AST_PULL_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall)); // R8
  AST_PULL_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_q) |-> $past(scl_fall || start_det || stop_det || illegal_now)); // R8
  AST_PULL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {TS_IDLE, TS_ADDR_RX, TS_WR_RX, TS_RD_PRELOAD, TS_RD_ACKCHK, TS_HALT})
      |-> !pull_q); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_active && start_det) |=> (st_q == TS_ADDR_RX) && !pull_q); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_active && stop_det) |=> (st_q == TS_IDLE) && !pull_q); // R7
  AST_NACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_RD_ACKCHK && scl_rise && sda_in && !start_det && !stop_det)
      |=> (st_q == TS_IDLE)); // R5
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R4
  AST_ILLEGAL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_now |=> (st_q == TS_HALT)); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_HALT) |=> (st_q == TS_HALT) && !pull_q); // R9

endmodule

// File: rtl/i2c_tgt_byte_ctrl.sv
module i2c_tgt_byte_ctrl #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_pull,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_req,
  output logic              fsm_err
);

  logic [DATA_W-1:0] full_byte;
  logic              sh_msb;
  logic              addr_hit;
  logic              rw_bit;
  logic              byte_done;
  logic              sh_in_en;
  logic              sh_ld_en;
  logic              sh_out_en;

  i2c_tgt_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_in_en  (sh_in_en),
    .in_bit       (sda_in),
    .load_en      (sh_ld_en),
    .load_val     (tx_data),
    .shift_out_en (sh_out_en),
    .sh_msb       (sh_msb),
    .full_byte    (full_byte)
  );

  i2c_tgt_addr_cmp #(.DATA_W(DATA_W)) u_addr_cmp (
    .full_byte (full_byte),
    .own_addr  (own_addr),
    .addr_hit  (addr_hit),
    .rw_bit    (rw_bit)
  );

  i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_in    (sda_in),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_hit  (addr_hit),
    .rw_bit    (rw_bit),
    .tx_msb    (tx_data[DATA_W-1]),
    .sh_msb    (sh_msb),
    .sda_pull  (sda_pull),
    .tx_req    (tx_req),
    .byte_done (byte_done),
    .sh_in_en  (sh_in_en),
    .sh_ld_en  (sh_ld_en),
    .sh_out_en (sh_out_en),
    .halted    (fsm_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= byte_done;
      if (byte_done) rx_byte <= full_byte;
    end
  end

  AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3
  AST_NO_OUTPUT_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_err |-> !sda_pull && !rx_valid); // R9

endmodule

// File: tb/i2c_tgt_byte_ctrl_bench.sv
module i2c_tgt_byte_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OWN = 7'h52;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
  logic       start_det = 1'b0, stop_det = 1'b0;
  logic [6:0] own_addr = OWN;
  logic [7:0] tx_data = 8'h00;
  logic       sda_pull, rx_valid, tx_req, fsm_err;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  bit done = 1'b0;
  logic [7:0] rx_exp[$];
  logic [7:0] rd_src[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_tgt_byte_ctrl u_i2c_tgt_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .tx_data(tx_data), .sda_pull(sda_pull),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_req(tx_req), .fsm_err(fsm_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask
  task automatic do_rise();
    @(negedge clk) scl_rise = 1'b1;
    @(negedge clk) scl_rise = 1'b0;
    gap();
  endtask
  task automatic do_fall();
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    gap();
  endtask
  task automatic do_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    gap();
  endtask
  task automatic do_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
    gap();
  endtask

  // Controller sends n bits of b, MSB first.
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_in = b[i];
      do_rise();
      do_fall();
    end
    sda_in = 1'b1;
  endtask

  // Controller clocks the ninth (acknowledge) slot.
  task automatic ack_clock();
    do_rise();
    do_fall();
  endtask

  // Controller reads a byte driven by the target.
  task automatic read_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      b[i] = ~sda_pull;
      do_rise();
      do_fall();
    end
  endtask

  // Host model: answer each request with the next queued byte.
  initial begin
    forever begin
      @(negedge clk);
      if (tx_req) begin
        req_cnt++;
        tx_data = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hEE;
      end
    end
  end

  // Scoreboard monitor for received write bytes (R3).
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        checks++;
        if (rx_exp.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected rx byte: actual=%0h expected=none", rx_byte);
        end else begin
          logic [7:0] e;
          e = rx_exp.pop_front();
          if (rx_byte !== e) begin
            errors++;
            $display("FAIL R3 rx byte: actual=%0h expected=%0h", rx_byte, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    gap();
    // R1 reset state
    chk("R1", "sda_pull", sda_pull, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "tx_req", tx_req, 0);
    chk("R1", "fsm_err", fsm_err, 0);

    // R2 address mismatch: no ACK, rest ignored
    do_start(); do_fall();
    send_bits({7'h53, 1'b0}, 8);
    chk("R2", "no ack on mismatch", sda_pull, 0);
    ack_clock();
    send_bits(8'h11, 8);
    chk("R2", "ignored after mismatch", sda_pull, 0);
    chk("R2", "no request on mismatch", req_cnt, 0);
    do_stop();

    // R2/R3 write of two bytes
    do_start(); do_fall();
    send_bits({OWN, 1'b0}, 8);
    chk("R2", "ack on match", sda_pull, 1);
    ack_clock();
    chk("R8", "released after ack", sda_pull, 0);
    rx_exp.push_back(8'hA5);
    send_bits(8'hA5, 8);
    chk("R3", "ack byte 1", sda_pull, 1);
    ack_clock();
    rx_exp.push_back(8'h3C);
    send_bits(8'h3C, 8);
    chk("R3", "ack byte 2", sda_pull, 1);
    ack_clock();
    do_stop();
    chk("R7", "released after stop", sda_pull, 0);
    chk("R3", "all bytes seen", rx_exp.size(), 0);

    // R4/R5 read of two bytes ending in NACK
    rd_src.push_back(8'h96);
    rd_src.push_back(8'h5A);
    do_start(); do_fall();
    send_bits({OWN, 1'b1}, 8);
    chk("R2", "ack read addr", sda_pull, 1);
    chk("R4", "request after addr", req_cnt, 1);
    ack_clock();
    read_byte(rd);
    chk("R4", "read byte 1", rd, 8'h96);
    chk("R8", "released in ack check", sda_pull, 0);
    sda_in = 1'b0; do_rise(); sda_in = 1'b1;
    chk("R4", "request after controller ack", req_cnt, 2);
    do_fall();
    read_byte(rd);
    chk("R4", "read byte 2", rd, 8'h5A);
    sda_in = 1'b1; do_rise(); do_fall();
    chk("R5", "released after nack", sda_pull, 0);
    send_bits(8'h00, 8);
    chk("R5", "idle after nack", sda_pull, 0);
    chk("R5", "no request after nack", req_cnt, 2);
    do_stop();

    // R6 repeated START in mid-byte, then read; R7 STOP while driving
    do_start(); do_fall();
    send_bits({OWN, 1'b0}, 8);
    ack_clock();
    rx_exp.push_back(8'h77);
    send_bits(8'h77, 8);
    ack_clock();
    send_bits(8'hFF, 3);
    do_start();
    chk("R6", "released at restart", sda_pull, 0);
    do_fall();
    rd_src.push_back(8'h0F);
    send_bits({OWN, 1'b1}, 8);
    chk("R6", "ack after restart", sda_pull, 1);
    ack_clock();
    chk("R4", "msb 0 drives low", sda_pull, 1);
    do_stop();
    chk("R7", "stop releases driven bit", sda_pull, 0);
    send_bits({OWN, 1'b0}, 8);
    chk("R7", "bits after stop ignored", sda_pull, 0);
    chk("R4", "request count", req_cnt, 3);

    // R7 STOP in the middle of a write byte
    do_start(); do_fall();
    send_bits({OWN, 1'b0}, 8);
    ack_clock();
    send_bits(8'hC3, 4);
    do_stop();
    send_bits(8'hC3, 8);
    chk("R7", "no ack after mid-byte stop", sda_pull, 0);

    // R9 illegal state injected while ACK is driven
    do_start(); do_fall();
    send_bits({OWN, 1'b0}, 8);
    chk("R2", "ack before injection", sda_pull, 1);
    @(negedge clk);
    force u_i2c_tgt_byte_ctrl.u_fsm.st_q = i2c_tgt_pkg::tgt_state_t'(4'hF);
    #1 release u_i2c_tgt_byte_ctrl.u_fsm.st_q;
    gap();
    chk("R9", "error flag", fsm_err, 1);
    chk("R9", "released in halt", sda_pull, 0);
    do_start(); do_fall();
    send_bits({OWN, 1'b0}, 8);
    chk("R9", "no ack in halt", sda_pull, 0);
    chk("R9", "halt sticky", fsm_err, 1);
    @(negedge clk) rst_n = 1'b0;
    gap();
    rst_n = 1'b1;
    gap();
    chk("R1", "error cleared by reset", fsm_err, 0);
    chk("R3", "scoreboard drained", rx_exp.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule